// File: doc/BRIEF.md
# Dual-Modulus 8/9 Clock Prescaler

This block divides a fast input clock by either eight or nine, chosen by a single select pin. It is the front stage of a programmable feedback divider: a pair of counters further down counts its output cycles and flips the select pin to set the overall ratio. Every output cycle therefore has to have exactly the length the select pin asked for, including the cycle in which the pin changes.

Inside, a three-flop core counts four or five input cycles per core cycle. A fourth flop toggles once per core cycle and is the output. In divide-by-nine mode, that flop tells the core to run four cycles while the output is high and five while it is low. In divide-by-eight mode, the core always runs four. All stages run on the single input clock, and the divide-by-2 stage is advanced through a clock enable. The select pin is captured at each rising output edge and held for the whole output cycle that follows. Reset is asynchronous in assertion and synchronous in release.

Top module: `dual_mod_prescaler`

## Requirements
- R1: While `rst_n` is low, `clk_out` is low. Asserting `rst_n` forces `clk_out` low without waiting for a clock edge.
- R2: After `rst_n` rises, the first rising edge of `clk_out` comes within RST_STAGES + 9 input cycles.
- R3: With `div8_sel` = 1, each output cycle lasts 8 input cycles: 4 high, then 4 low.
- R4: With `div8_sel` = 0, each output cycle lasts 9 input cycles: 4 high, then 5 low.
- R5: `div8_sel` is sampled at the input edge that raises `clk_out`. A change at any other time leaves the current output cycle unchanged, and the next output cycle takes the new ratio.
- R6: Every output high phase is exactly 4 input cycles long, in either mode and across mode changes. No shortened (runt) pulse occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Fast input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| div8_sel | input | 1 | Ratio select: 1 divides by 8, 0 divides by 9 |
| clk_out | output | 1 | Prescaled clock |

## Verification
An illegal core state, or a wrong feedback term, shows up within one output cycle as a high or low phase of the wrong length. The bench therefore measures every high and low phase in input cycles, and compares each against the ratio it expects. A select capture at the wrong moment shows up differently: the cycle in which `div8_sel` moves takes the new length too early. Mode changes are therefore placed early in the high phase, deep in the low phase and one cycle before the boundary. A bad reset path shows up as a high output during reset, or as a late first edge.

// File: rtl/dmp_pkg.sv
package dmp_pkg;
  // State of the four/five core: a two-flop ring plus one delay flop.
  typedef struct packed {
    logic ring_a;
    logic ring_b;
    logic dly;
  } core_state_t;

  localparam int DMP_RST_STAGES_DEF = 2;
endpackage

// File: rtl/dmp_rst_sync.sv
module dmp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] shreg;
  logic [LAST:0] shreg_nxt;

  // Shift a one in from the low end.
  always_comb begin
    shreg_nxt = {shreg[LAST-1:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      shreg <= '0;
    end else begin
      shreg <= shreg_nxt;
    end
  end

  assign rst_n_sync = shreg[LAST];
endmodule

// File: rtl/dmp_core45.sv
module dmp_core45
  import dmp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ext5,       // 1: stretch this core cycle to five input cycles
  output logic core_rise   // the core output rises at the next edge
);
  core_state_t cur;
  core_state_t nxt;

  // Ring feedback, with the delayed term ORed in when stretching is allowed.
  always_comb begin
    nxt.ring_a = ~(cur.ring_b | (ext5 & cur.dly));
    nxt.ring_b = cur.ring_a;
    nxt.dly    = cur.ring_b;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur <= '0;
    end else begin
      cur <= nxt;
    end
  end

  assign core_rise = cur.ring_a & ~cur.ring_b;

  // R4
  // only 000,100,110,011,001 may be visited
  legal_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur != 3'b010) && (cur != 3'b101) && (cur != 3'b111));

  // R6
  high_pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cur.ring_b) |=> cur.ring_b);

  // R6
  low_pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cur.ring_b) |=> !cur.ring_b);
endmodule

// File: rtl/dmp_half.sv
module dmp_half (
  input  logic clk,
  input  logic rst_n,
  input  logic adv_en,
  output logic q
);
  logic q_nxt;

  always_comb begin
    q_nxt = adv_en ? ~q : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= 1'b0;
    end else begin
      q <= q_nxt;
    end
  end
endmodule

// File: rtl/dual_mod_prescaler.sv
module dual_mod_prescaler
  import dmp_pkg::*;
#(
  parameter int RST_STAGES = DMP_RST_STAGES_DEF
) (
  input  logic clk_in,
  input  logic rst_n,
  input  logic div8_sel,
  output logic clk_out
);
  logic rst_int_n;
  logic core_rise;
  logic half_q;
  logic mode8_q;
  logic mode8_nxt;
  logic cap_en;
  logic stretch;

  dmp_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk         (clk_in),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_int_n)
  );

  dmp_core45 u_core (
    .clk       (clk_in),
    .rst_n     (rst_int_n),
    .ext5      (stretch),
    .core_rise (core_rise)
  );

  dmp_half u_half (
    .clk    (clk_in),
    .rst_n  (rst_int_n),
    .adv_en (core_rise),
    .q      (half_q)
  );

  // Capture the select pin on the edge that raises the output.
  always_comb begin
    cap_en    = core_rise & ~half_q;
    mode8_nxt = cap_en ? div8_sel : mode8_q;
    stretch   = ~mode8_q & ~half_q;
  end

  always_ff @(posedge clk_in or negedge rst_int_n) begin
    if (!rst_int_n) begin
      mode8_q <= 1'b1;
    end else begin
      mode8_q <= mode8_nxt;
    end
  end

  assign clk_out = half_q;

  // R3
  out_step_chk: assert property (@(posedge clk_in) disable iff (!rst_int_n)
    !$stable(clk_out) |-> $past(core_rise));

  // R5
  mode_hold_chk: assert property (@(posedge clk_in) disable iff (!rst_int_n)
    !$rose(clk_out) |-> $stable(mode8_q));
endmodule

// File: tb/dual_mod_prescaler_test.sv
module dual_mod_prescaler_test;
  logic clk_in = 1'b0;
  logic rst_n;
  logic div8_sel;
  logic clk_out;
  int checks = 0;
  int errors = 0;
  localparam int STG = 2;

  always #2 clk_in = ~clk_in;

  dual_mod_prescaler #(.RST_STAGES(STG)) uut (
    .clk_in   (clk_in),
    .rst_n    (rst_n),
    .div8_sel (div8_sel),
    .clk_out  (clk_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_rise();
    bit prev;
    @(negedge clk_in);
    prev = clk_out;
    while (1) begin
      @(negedge clk_in);
      if (clk_out && !prev) break;
      prev = clk_out;
    end
  endtask

  // Starts at the negedge where clk_out was first seen high; ends at the next such negedge.
  task automatic measure(output int hi, output int lo);
    hi = 1;
    while (1) begin
      @(negedge clk_in);
      if (clk_out) hi++; else break;
    end
    lo = 1;
    while (1) begin
      @(negedge clk_in);
      if (!clk_out) lo++; else break;
    end
  endtask

  task automatic release_and_first_edge();
    int n;
    @(posedge clk_in); #1 rst_n = 1'b1;
    n = 0;
    while (1) begin
      @(negedge clk_in);
      n++;
      if (clk_out || n > 40) break;
    end
    // R2
    chk(clk_out && n <= STG + 9, "R2 first edge delay", n, STG + 9);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    div8_sel = 1'b1;
    repeat (5) @(posedge clk_in);
    @(negedge clk_in);
    // R1
    chk(clk_out == 1'b0, "R1 out during reset", clk_out, 0);
    release_and_first_edge();
  endtask

  task automatic t_div8();
    int hi, lo;
    wait_rise();
    for (int i = 0; i < 3; i++) begin
      measure(hi, lo);
      chk(hi == 4, "R6 high length div8", hi, 4);
      chk(lo == 4, "R3 low length div8", lo, 4);
    end
  endtask

  task automatic t_div9();
    int hi, lo;
    @(posedge clk_in); #1 div8_sel = 1'b0;
    wait_rise();
    for (int i = 0; i < 3; i++) begin
      measure(hi, lo);
      chk(hi == 4, "R6 high length div9", hi, 4);
      chk(lo == 5, "R4 low length div9", lo, 5);
    end
  endtask

  task automatic t_switch(input bit new_sel, input int delay);
    int hi, lo;
    bit old_sel;
    old_sel = div8_sel;
    wait_rise();
    fork
      measure(hi, lo);
      begin
        repeat (delay) @(posedge clk_in);
        #1 div8_sel = new_sel;
      end
    join
    // R5: the cycle in progress keeps the old ratio
    chk(lo == (old_sel ? 4 : 5), "R5 cycle during change", lo, old_sel ? 4 : 5);
    chk(hi == 4, "R6 high during change", hi, 4);
    measure(hi, lo);
    chk(lo == (new_sel ? 4 : 5), "R5 cycle after change", lo, new_sel ? 4 : 5);
    chk(hi == 4, "R6 high after change", hi, 4);
  endtask

  task automatic t_reset_midway();
    int hi, lo;
    wait_rise();
    @(posedge clk_in); #1 rst_n = 1'b0;
    #0.5;
    // R1: asynchronous clear
    chk(clk_out == 1'b0, "R1 async clear", clk_out, 0);
    repeat (3) @(posedge clk_in);
    release_and_first_edge();
    measure(hi, lo);
    chk(hi == 4, "R6 high after reset", hi, 4);
    chk(lo == (div8_sel ? 4 : 5), "R4 low after reset", lo, div8_sel ? 4 : 5);
  endtask

  initial begin
    repeat (20000) @(posedge clk_in);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_div8();
    t_div9();
    t_switch(1'b1, 8);
    t_switch(1'b0, 1);
    t_switch(1'b1, 6);
    t_switch(1'b0, 7);
    t_reset_midway();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule